// File: doc/BRIEF.md
# Programmable Product-Term AND Plane

This block evaluates the product terms of one logic block in a wide-input programmable-logic fabric. Each of the `N_IN` inputs is offered as a true line and as a complement line. Every product term holds a row of connection bits, one bit per line. The term is the wired AND of every line whose bit is set. With the defaults there are 68 inputs, 136 lines and 163 terms.

The first `5 * N_CELL` terms are logic terms. They are grouped in clusters of five consecutive terms, and cluster k serves cell k. Four members of a cluster can be taken out of the sum and used as a per-cell control signal for that cell. Each logic term has a steer bit that makes this choice. The last three terms always act as the shared clock, shared reset and shared output enable of the whole block. Configuration arrives one row at a time on a parallel write port.

The term outputs are combinational from the inputs and the stored configuration. The configuration itself is registered.

Top module: `pt_and_plane`

## Requirements
- R1: Input bit i drives line 2i in true form and line 2i+1 in complement form. A term is 1 when every line whose bit is set in the term's row is 1, so `row[2i]` requires `in_i[i]=1` and `row[2i+1]` requires `in_i[i]=0`.
- R2: On a clock edge with `cfg_we_i=1` and `cfg_addr_i` below the term count, the row bits `cfg_line_i` of that term are stored. For a logic term the steer bit `cfg_steer_i` is stored as well. The outputs show the new row from that edge onwards.
- R3: A write with `cfg_addr_i` at or above the term count changes no stored row and no steer bit.
- R4: A term whose row has no bit set is 1 for every input value.
- R5: A term whose row sets both lines of the same input is 0 for every input value.
- R6: While `rst_ni` is low, every row and steer bit is cleared. In that state all `sum_pt_o` bits are 1, all per-cell control outputs are 0, and all three shared outputs are 1.
- R7: `sum_pt_o[t]` equals logic term t, unless that term is steered to a control role. A steered term gives 0 on `sum_pt_o[t]`.
- R8: Cluster member 2 of cell k maps to `cell_clk_o[k]`, member 3 to `cell_set_o[k]` and member 4 to `cell_rst_o[k]`. Each of these outputs equals its term when the term's steer bit is 1, and is 0 otherwise.
- R9: Cluster member 1 has no control role. Its steer bit is ignored, and the term always reaches `sum_pt_o`.
- R10: Member 0 of cell k drives `cell_oe_o[k]` only when bit k of `OE_CELL_MASK` is set. For any other cell, its steer bit is ignored, the term stays in the sum, and `cell_oe_o[k]` is 0.
- R11: Terms `5*N_CELL`, `5*N_CELL+1` and `5*N_CELL+2` drive `shr_clk_o`, `shr_rst_o` and `shr_oe_o` directly. Steer bits written to these rows are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Row write strobe |
| cfg_addr_i | input | $clog2(5*N_CELL+3) | Term index to write |
| cfg_line_i | input | 2*N_IN | Connection bits for the addressed term |
| cfg_steer_i | input | 1 | Control-role steer bit for the addressed term |
| in_i | input | N_IN | Plane inputs |
| sum_pt_o | output | 5*N_CELL | Logic terms presented to the sum plane |
| cell_oe_o | output | N_CELL | Per-cell output-enable terms |
| cell_clk_o | output | N_CELL | Per-cell clock terms |
| cell_set_o | output | N_CELL | Per-cell preset terms |
| cell_rst_o | output | N_CELL | Per-cell reset terms |
| shr_clk_o | output | 1 | Shared clock term |
| shr_rst_o | output | 1 | Shared reset term |
| shr_oe_o | output | 1 | Shared output-enable term |

## Verification
The bench uses 3 inputs and 3 cells, with cell 1 marked as having no output enable. It sweeps all eight input values after each configuration load and compares every output.

It covers the following corner cases, each with the fault it would expose:
- **Empty rows.** A design that treats an empty row as 0 fails R4.
- **Contradictory rows.** A design that mishandles a row holding both lines of one input fails R5.
- **Swapped line polarity.** A design that reverses true and complement lines shows inverted terms.
- **Steer on member 1 and on a non-output cell's member 0.** A design that honours these steer bits drops terms from the sum.
- **Steer bits on the shared rows.** A design that uses them gates the shared controls.
- **Writes above the last row.** A design that aliases these addresses onto real rows corrupts them.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int unsigned DEF_N_IN    = 68;
  localparam int unsigned DEF_N_CELL  = 32;
  localparam int unsigned CLUSTER_SZ  = 5;
  localparam int unsigned N_SHARED    = 3;

  // member index inside a cluster and its control role
  typedef enum logic [2:0] {
    ROLE_OE   = 3'd0,
    ROLE_NONE = 3'd1,
    ROLE_CLK  = 3'd2,
    ROLE_SET  = 3'd3,
    ROLE_RST  = 3'd4
  } pt_role_e;

  function automatic pt_role_e role_of(input int unsigned member);
    return pt_role_e'(member[2:0]);
  endfunction
endpackage

// File: rtl/pt_cfg_store.sv
module pt_cfg_store #(
  parameter int unsigned N_TERM  = 163,
  parameter int unsigned N_LOGIC = 160,
  parameter int unsigned N_LINE  = 136,
  parameter int unsigned AW      = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [AW-1:0]                  addr_i,
  input  logic [N_LINE-1:0]              line_i,
  input  logic                           steer_i,
  output logic [N_TERM-1:0][N_LINE-1:0]  rows_o,
  output logic [N_LOGIC-1:0]             steer_o
);
  localparam logic [AW-1:0] LAST_ROW = AW'(N_TERM - 1);

  logic                          hit;
  logic [N_TERM-1:0][N_LINE-1:0] rows_q;
  logic [N_LOGIC-1:0]            steer_q;

  assign hit = we_i && (addr_i <= LAST_ROW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rows_q  <= '0;
      steer_q <= '0;
    end else if (hit) begin
      for (int r = 0; r < N_TERM; r++)
        if (addr_i == AW'(r)) rows_q[r] <= line_i;
      for (int r = 0; r < N_LOGIC; r++)
        if (addr_i == AW'(r)) steer_q[r] <= steer_i;
    end
  end

  assign rows_o  = rows_q;
  assign steer_o = steer_q;

  AST_ROW_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (rows_q[$past(addr_i)] == $past(line_i))); // R2
  AST_OOR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit) |=> ($stable(rows_q) && $stable(steer_q))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rows_q)); // R2
endmodule

// File: rtl/pt_term_eval.sv
module pt_term_eval #(
  parameter int unsigned N_IN   = 68,
  parameter int unsigned N_TERM = 163,
  localparam int unsigned N_LINE = 2 * N_IN
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_IN-1:0]                in_i,
  input  logic [N_TERM-1:0][N_LINE-1:0]  rows_i,
  output logic [N_TERM-1:0]              term_o
);
  logic [N_LINE-1:0] lines;

  for (genvar i = 0; i < N_IN; i++) begin : g_line
    assign lines[2*i]   = in_i[i];
    assign lines[2*i+1] = ~in_i[i];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] clash;
    // unconnected lines read as 1 in the wired AND
    assign term_o[t] = &(~rows_i[t] | lines);

    for (genvar i = 0; i < N_IN; i++) begin : g_clash
      assign clash[i] = rows_i[t][2*i] & rows_i[t][2*i+1];
    end

    AST_EMPTY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rows_i[t] == '0) |-> term_o[t]); // R4
    AST_CLASH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|clash) |-> !term_o[t]); // R5
  end
endmodule

// File: rtl/pt_role_map.sv
module pt_role_map
  import pt_pkg::*;
#(
  parameter int unsigned       N_CELL      = 32,
  parameter logic [N_CELL-1:0] OE_CELL_MASK = '1,
  localparam int unsigned      N_LOGIC     = CLUSTER_SZ * N_CELL
) (
  input  logic [N_LOGIC-1:0] term_i,
  input  logic [N_LOGIC-1:0] steer_i,
  output logic [N_LOGIC-1:0] sum_o,
  output logic [N_CELL-1:0]  oe_o,
  output logic [N_CELL-1:0]  clk_o,
  output logic [N_CELL-1:0]  set_o,
  output logic [N_CELL-1:0]  rst_o
);
  for (genvar k = 0; k < N_CELL; k++) begin : g_cell
    logic [CLUSTER_SZ-1:0] ctl;
    for (genvar m = 0; m < CLUSTER_SZ; m++) begin : g_member
      localparam pt_role_e ROLE = role_of(m);
      localparam bit CAPABLE = (ROLE == ROLE_OE) ? bit'(OE_CELL_MASK[k])
                                                 : (ROLE != ROLE_NONE);
      localparam int unsigned T = CLUSTER_SZ * k + m;
      logic take;
      assign take           = steer_i[T] & CAPABLE;
      assign sum_o[T]       = term_i[T] & ~take;
      assign ctl[m]         = term_i[T] & take;
    end
    assign oe_o[k]  = ctl[ROLE_OE];
    assign clk_o[k] = ctl[ROLE_CLK];
    assign set_o[k] = ctl[ROLE_SET];
    assign rst_o[k] = ctl[ROLE_RST];
  end
endmodule

// File: rtl/pt_and_plane.sv
module pt_and_plane
  import pt_pkg::*;
#(
  parameter int unsigned       N_IN         = DEF_N_IN,
  parameter int unsigned       N_CELL       = DEF_N_CELL,
  parameter logic [N_CELL-1:0] OE_CELL_MASK = '1,
  localparam int unsigned      N_LOGIC      = CLUSTER_SZ * N_CELL,
  localparam int unsigned      N_TERM       = N_LOGIC + N_SHARED,
  localparam int unsigned      N_LINE       = 2 * N_IN,
  localparam int unsigned      AW           = $clog2(N_TERM)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [AW-1:0]      cfg_addr_i,
  input  logic [N_LINE-1:0]  cfg_line_i,
  input  logic               cfg_steer_i,
  input  logic [N_IN-1:0]    in_i,
  output logic [N_LOGIC-1:0] sum_pt_o,
  output logic [N_CELL-1:0]  cell_oe_o,
  output logic [N_CELL-1:0]  cell_clk_o,
  output logic [N_CELL-1:0]  cell_set_o,
  output logic [N_CELL-1:0]  cell_rst_o,
  output logic               shr_clk_o,
  output logic               shr_rst_o,
  output logic               shr_oe_o
);
  logic [N_TERM-1:0][N_LINE-1:0] rows;
  logic [N_LOGIC-1:0]            steer;
  logic [N_TERM-1:0]             term;

  pt_cfg_store #(
    .N_TERM (N_TERM),
    .N_LOGIC(N_LOGIC),
    .N_LINE (N_LINE),
    .AW     (AW)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .line_i (cfg_line_i),
    .steer_i(cfg_steer_i),
    .rows_o (rows),
    .steer_o(steer)
  );

  pt_term_eval #(
    .N_IN  (N_IN),
    .N_TERM(N_TERM)
  ) u_eval (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (in_i),
    .rows_i(rows),
    .term_o(term)
  );

  pt_role_map #(
    .N_CELL      (N_CELL),
    .OE_CELL_MASK(OE_CELL_MASK)
  ) u_roles (
    .term_i (term[N_LOGIC-1:0]),
    .steer_i(steer),
    .sum_o  (sum_pt_o),
    .oe_o   (cell_oe_o),
    .clk_o  (cell_clk_o),
    .set_o  (cell_set_o),
    .rst_o  (cell_rst_o)
  );

  assign shr_clk_o = term[N_LOGIC];
  assign shr_rst_o = term[N_LOGIC+1];
  assign shr_oe_o  = term[N_LOGIC+2];

  for (genvar k = 0; k < N_CELL; k++) begin : g_chk
    localparam int unsigned B = CLUSTER_SZ * k;
    AST_ROLE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sum_pt_o[B+2] && cell_clk_o[k]) && !(sum_pt_o[B+3] && cell_set_o[k])
      && !(sum_pt_o[B+4] && cell_rst_o[k])); // R8
    AST_FREE_MEMBER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sum_pt_o[B+1] == term[B+1]); // R9
    if (!OE_CELL_MASK[k]) begin : g_no_oe
      AST_NO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cell_oe_o[k] && (sum_pt_o[B] == term[B])); // R10
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (cell_clk_o == '0 && cell_set_o == '0 && cell_rst_o == '0)); // R6
endmodule

// File: tb/pt_and_plane_test.sv
module pt_and_plane_test;
  localparam int NI = 3;
  localparam int NC = 3;
  localparam int NL = 5 * NC;
  localparam int NT = NL + 3;
  localparam int LW = 2 * NI;
  localparam int AW = $clog2(NT);
  localparam logic [NC-1:0] OE_MASK = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LW-1:0] line = '0;
  logic steer_in = 1'b0;
  logic [NI-1:0] din = '0;
  logic [NL-1:0] sum_pt;
  logic [NC-1:0] c_oe, c_clk, c_set, c_rst;
  logic s_clk, s_rst, s_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [LW-1:0] m_row [NT];
  logic          m_steer [NL];

  always #4 clk = ~clk;

  pt_and_plane #(.N_IN(NI), .N_CELL(NC), .OE_CELL_MASK(OE_MASK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_line_i(line), .cfg_steer_i(steer_in), .in_i(din),
    .sum_pt_o(sum_pt), .cell_oe_o(c_oe), .cell_clk_o(c_clk),
    .cell_set_o(c_set), .cell_rst_o(c_rst),
    .shr_clk_o(s_clk), .shr_rst_o(s_rst), .shr_oe_o(s_oe));

  task automatic cmp(input string tag, input string ph, input logic [31:0] got,
                     input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s (%s) in=%0d got=%h exp=%h", tag, ph, din, got, exp);
    end
  endtask

  // R1: line 2i needs in=1, line 2i+1 needs in=0
  function automatic logic term_val(input int t, input logic [NI-1:0] v);
    logic r = 1'b1;
    for (int i = 0; i < NI; i++) begin
      if (m_row[t][2*i] && !v[i]) r = 1'b0;
      if (m_row[t][2*i+1] && v[i]) r = 1'b0;
    end
    return r;
  endfunction

  task automatic check_all(input string ph);
    logic [NL-1:0] e_sum;
    logic [NC-1:0] e_oe, e_clk, e_set, e_rst;
    logic [2:0] e_shr;
    for (int k = 0; k < NC; k++) begin
      for (int m = 0; m < 5; m++) begin
        int t = 5 * k + m;
        logic tv = term_val(t, din);
        logic en = m_steer[t] && ((m == 0) ? OE_MASK[k] : (m != 1));
        e_sum[t] = tv && !en;
        case (m)
          0: e_oe[k]  = tv && en;
          2: e_clk[k] = tv && en;
          3: e_set[k] = tv && en;
          4: e_rst[k] = tv && en;
          default: ;
        endcase
      end
    end
    e_shr = {term_val(NL + 2, din), term_val(NL + 1, din), term_val(NL, din)};
    cmp("R7", ph, 32'(sum_pt), 32'(e_sum));
    cmp("R10", ph, 32'(c_oe), 32'(e_oe));
    cmp("R8 clk", ph, 32'(c_clk), 32'(e_clk));
    cmp("R8 set", ph, 32'(c_set), 32'(e_set));
    cmp("R8 rst", ph, 32'(c_rst), 32'(e_rst));
    cmp("R11", ph, 32'({s_oe, s_rst, s_clk}), 32'(e_shr));
  endtask

  task automatic sweep(input string ph);
    for (int v = 0; v < (1 << NI); v++) begin
      @(negedge clk);
      din = NI'(v);
      #2 check_all(ph);
    end
  endtask

  task automatic wr(input int a, input logic [LW-1:0] d, input logic s);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); line = d; steer_in = s;
    @(negedge clk);
    we = 1'b0;
    // R2: model updates for in-range rows only, R3 otherwise
    if (a < NT) begin
      m_row[a] = d;
      if (a < NL) m_steer[a] = s;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) m_row[t] = '0;
    for (int t = 0; t < NL; t++) m_steer[t] = 1'b0;
    // R6: reset state, swept while held in reset
    sweep("R6 reset");
    @(negedge clk);
    rst_n = 1'b1;
    sweep("R6 after release");

    // R4 empty, R5 clash, R1 single literals; all steer bits set (R9, R10, R11)
    for (int t = 0; t < NT; t++) wr(t, LW'($urandom % 64), 1'b1);
    wr(0, 6'b000000, 1'b1);          // R4
    wr(1, 6'b000011, 1'b1);          // R5 input 0 both polarities
    wr(2, 6'b000001, 1'b1);          // R1 in0 true
    wr(3, 6'b001000, 1'b1);          // R1 in1 complement
    wr(5, 6'b000000, 1'b1);          // R10 cell 1 member 0, no oe
    wr(6, 6'b110000, 1'b1);          // R9 member 1, clash on in2
    wr(NL, 6'b000000, 1'b1);         // R11 shared clk empty
    wr(NL + 2, 6'b100000, 1'b1);     // R11 shared oe, in2 complement
    sweep("R1 R4 R5 R9 steer set");

    for (int t = 0; t < NL; t++) wr(t, m_row[t], 1'b0);
    sweep("R7 steer clear");

    for (int round = 0; round < 12; round++) begin
      for (int t = 0; t < NT; t++) wr(t, LW'($urandom % 64), 1'($urandom % 2));
      sweep("R2 random load");
    end

    // R3: writes above the last row leave everything intact
    for (int a = NT; a < (1 << AW); a++) wr(a, LW'($urandom % 64), 1'b1);
    sweep("R3 out of range");

    // R2: single-row rewrite takes effect after its edge
    wr(7, 6'b000100, 1'b1);
    sweep("R2 rewrite");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule